// File: doc/BRIEF.md
# Oversampling Serial Receiver with Three-Sample Voting

This block receives asynchronous serial characters on a single line. It samples the line through a two-flop synchroniser. A sample counter advances only on cycles where an external oversampling tick is high. The tick arrives at 16 times the baud rate in normal mode and 8 times in double mode. Every bit, including the start and stop bits, is decided by a majority of three samples around the middle of the bit. A single corrupted sample therefore does not change the received value.

A character has between 5 and 9 data bits, sent least significant bit first. An even or odd parity bit may follow the data bits. After the data comes one stop bit. Once the stop bit has been voted, the block presents the character, a frame-error flag and a parity-error flag, together with a single-cycle valid strobe. The receiver returns to idle at once at that point, so a start edge can be accepted straight after the stop bit's last voting sample. Tick generation, buffering and transmit belong to the surrounding logic.

Top module: `uart_rx_core`

## Requirements
- R1: A bit lasts 16 ticks when `dbl_speed_i` is 0 and 8 ticks when it is 1. Clock cycles without `tick_i` do not advance sampling, so the result does not depend on the tick spacing.
- R2: Each bit's value is the majority of samples 8, 9 and 10 (normal) or 4, 5 and 6 (double), where sample 1 is the first tick with the start level. One wrong sample in that window leaves the bit unchanged, two wrong samples flip it, and samples outside the window have no effect.
- R3: While idle, a falling edge of the synchronised line starts a frame. If the start bit votes 1, the event is discarded, no strobe is produced, and the receiver waits for the next edge.
- R4: Data bits arrive LSB first. `char_bits_i` selects 5 to 9 data bits, and values below 5 are treated as 5. `rx_data_o` bits at and above the character size read 0.
- R5: `parity_mode_i` is 2'b00 for none, 2'b01 for even, 2'b10 for odd, and 2'b11 is treated as none. With parity enabled, a parity bit follows the last data bit, and a mismatch sets `parity_err_o`. Without parity, `parity_err_o` stays 0.
- R6: The stop bit is voted like any data bit. A vote of 0 sets `frame_err_o` for that character while the data is still delivered.
- R7: The receiver is idle again on the tick after the stop bit's last voting sample. A start edge on the very next sample is accepted, so a stop bit cut short just after its voting window does not cost the next character.
- R8: `rx_valid_o` is high for exactly one clock per character. `rx_data_o`, `frame_err_o` and `parity_err_o` change only with it and hold until the next character.
- R9: While `rst_ni` is low, the receiver is idle and all outputs read 0. This holds even in the middle of a frame, and the next frame after release is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick enable, one cycle per sample |
| dbl_speed_i | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| char_bits_i | input | 4 | Data bits per character, 5 to 9 |
| parity_mode_i | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| rxd_i | input | 1 | Serial line, idle high |
| rx_data_o | output | 9 | Received character, right aligned |
| rx_valid_o | output | 1 | One-cycle strobe for a new character |
| frame_err_o | output | 1 | Stop bit voted 0 |
| parity_err_o | output | 1 | Parity mismatch |

## Verification
The bench corrupts chosen samples inside and just outside the voting window, in both speed modes. A design that voted at the wrong positions, or took a single sample, would return a flipped bit or miss a genuine flip. It sends short low glitches on an idle line: a receiver without start confirmation would emit a bogus character. It cuts a stop bit off right after its voting window and starts the next character at once: a receiver that waits out the full stop bit would miss or misalign the second character. It also covers a slow, uneven tick rate, parity of both senses with good and bad bits, a low stop bit, a clamped character size and a reset in the middle of a frame. Wrong counting, parity sense or flag clearing each show up as wrong data or wrong flags.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= RST_VAL;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int OSR_NORM = 16,
  parameter int OSR_DBL  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic dbl_i,
  input  logic run_i,
  input  logic restart_i,
  input  logic rxs_i,
  output logic vote_o,
  output logic vote_stb_o
);
  localparam int CW = $clog2(OSR_NORM + 1);
  localparam logic [CW-1:0] LEN_N   = CW'(OSR_NORM);
  localparam logic [CW-1:0] LEN_D   = CW'(OSR_DBL);
  localparam logic [CW-1:0] FIRST_N = CW'(OSR_NORM / 2);
  localparam logic [CW-1:0] FIRST_D = CW'(OSR_DBL / 2);

  logic [CW-1:0] cnt_q, len, first, samp_num;
  logic          s_a_q, s_b_q;

  // samp_num: index of the sample taken on the current tick
  always_comb begin
    len      = dbl_i ? LEN_D : LEN_N;
    first    = dbl_i ? FIRST_D : FIRST_N;
    samp_num = (cnt_q >= len) ? CW'(1) : cnt_q + CW'(1);
  end

  assign vote_stb_o = run_i && tick_i && (samp_num == first + CW'(2));
  assign vote_o     = (s_a_q & s_b_q) | (s_a_q & rxs_i) | (s_b_q & rxs_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      s_a_q <= 1'b1;
      s_b_q <= 1'b1;
    end else if (restart_i) begin
      cnt_q <= CW'(1);
    end else if (run_i && tick_i) begin
      cnt_q <= samp_num;
      if (samp_num == first)          s_a_q <= rxs_i;
      if (samp_num == first + CW'(1)) s_b_q <= rxs_i;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame import uart_rx_pkg::*; #(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 9,
  parameter int CBW      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rxs_i,
  input  logic                dbl_i,
  input  logic [CBW-1:0]      char_bits_i,
  input  logic [1:0]          parity_mode_i,
  input  logic                vote_i,
  input  logic                vote_stb_i,
  output logic                restart_o,
  output logic                run_o,
  output logic                dbl_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                frame_err_o,
  output logic                parity_err_o
);
  rx_state_e           state_q;
  logic                last_q, dbl_q, par_acc_q, perr_q, has_par;
  logic [CBW-1:0]      nbits_q, idx_q, nbits_in;
  logic [1:0]          pmode_q;
  logic [MAX_BITS-1:0] shreg_q;

  always_comb begin
    if (char_bits_i < CBW'(MIN_BITS))      nbits_in = CBW'(MIN_BITS);
    else if (char_bits_i > CBW'(MAX_BITS)) nbits_in = CBW'(MAX_BITS);
    else                                   nbits_in = char_bits_i;
  end

  assign has_par   = (pmode_q == PAR_EVEN) || (pmode_q == PAR_ODD);
  assign restart_o = (state_q == ST_IDLE) && tick_i && last_q && !rxs_i;
  assign run_o     = (state_q != ST_IDLE);
  assign dbl_o     = dbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      last_q       <= 1'b1;
      dbl_q        <= 1'b0;
      par_acc_q    <= 1'b0;
      perr_q       <= 1'b0;
      nbits_q      <= CBW'(MAX_BITS);
      idx_q        <= '0;
      pmode_q      <= PAR_NONE;
      shreg_q      <= '0;
      data_o       <= '0;
      valid_o      <= 1'b0;
      frame_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (restart_o) begin
            state_q   <= ST_START;
            dbl_q     <= dbl_i;
            nbits_q   <= nbits_in;
            pmode_q   <= parity_mode_i;
            shreg_q   <= '0;
            idx_q     <= '0;
            par_acc_q <= 1'b0;
            perr_q    <= 1'b0;
          end else if (tick_i) begin
            last_q <= rxs_i;
          end
        end
        ST_START: begin
          if (vote_stb_i) begin
            if (vote_i) begin
              state_q <= ST_IDLE;  // glitch
              last_q  <= 1'b1;
            end else begin
              state_q <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (vote_stb_i) begin
            shreg_q[idx_q] <= vote_i;
            par_acc_q      <= par_acc_q ^ vote_i;
            idx_q          <= idx_q + CBW'(1);
            if (idx_q == nbits_q - CBW'(1))
              state_q <= has_par ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          if (vote_stb_i) begin
            perr_q  <= par_acc_q ^ vote_i ^ (pmode_q == PAR_ODD);
            state_q <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (vote_stb_i) begin
            valid_o      <= 1'b1;
            data_o       <= shreg_q;
            frame_err_o  <= ~vote_i;
            parity_err_o <= perr_q;
            last_q       <= vote_i;
            state_q      <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_GLITCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && vote_stb_i && vote_i) |=> (state_q == ST_IDLE && !valid_o)); // R3
  AST_NO_PERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !has_par) |-> !parity_err_o); // R5
  AST_STOP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && vote_stb_i) |=> (valid_o && frame_err_o == !$past(vote_i))); // R6
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && vote_stb_i) |=> (state_q == ST_IDLE)); // R7
  AST_VALID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int  MIN_BITS    = 5,
  parameter int  MAX_BITS    = 9,
  parameter int  OSR_NORM    = 16,
  parameter int  OSR_DBL     = 8,
  parameter int  SYNC_STAGES = 2,
  localparam int CBW         = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                dbl_speed_i,
  input  logic [CBW-1:0]      char_bits_i,
  input  logic [1:0]          parity_mode_i,
  input  logic                rxd_i,
  output logic [MAX_BITS-1:0] rx_data_o,
  output logic                rx_valid_o,
  output logic                frame_err_o,
  output logic                parity_err_o
);
  logic rxs, vote, vote_stb, restart, run, dbl;

  uart_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxs)
  );

  uart_rx_sampler #(.OSR_NORM(OSR_NORM), .OSR_DBL(OSR_DBL)) u_samp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .dbl_i     (dbl),
    .run_i     (run),
    .restart_i (restart),
    .rxs_i     (rxs),
    .vote_o    (vote),
    .vote_stb_o(vote_stb)
  );

  uart_rx_frame #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS), .CBW(CBW)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .rxs_i        (rxs),
    .dbl_i        (dbl_speed_i),
    .char_bits_i  (char_bits_i),
    .parity_mode_i(parity_mode_i),
    .vote_i       (vote),
    .vote_stb_i   (vote_stb),
    .restart_o    (restart),
    .run_o        (run),
    .dbl_o        (dbl),
    .data_o       (rx_data_o),
    .valid_o      (rx_valid_o),
    .frame_err_o  (frame_err_o),
    .parity_err_o (parity_err_o)
  );
endmodule

// File: tb/sim_uart_rx_core.sv
`timescale 1ns/1ps
module sim_uart_rx_core;
  logic       clk = 1'b0, rst_n = 1'b0, tick, dbl = 1'b0, rxd = 1'b1;
  logic [3:0] cbits = 4'd8;
  logic [1:0] pmode = 2'b00;
  logic [8:0] data;
  logic       valid, ferr, perr;

  int checks = 0, errs = 0;
  int tick_div = 1, tdiv_cnt = 0;
  int n_got = 0, wide_err = 0;
  logic [8:0] got_d [64];
  logic       got_fe [64];
  logic       got_pe [64];
  logic       prev_v = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) tdiv_cnt <= (tdiv_cnt >= tick_div - 1) ? 0 : tdiv_cnt + 1;
  assign tick = (tdiv_cnt == 0);

  uart_rx_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .dbl_speed_i(dbl),
    .char_bits_i(cbits), .parity_mode_i(pmode), .rxd_i(rxd),
    .rx_data_o(data), .rx_valid_o(valid), .frame_err_o(ferr), .parity_err_o(perr)
  );

  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (n_got < 64) begin
        got_d[n_got]  = data;
        got_fe[n_got] = ferr;
        got_pe[n_got] = perr;
      end
      n_got++;
      if (prev_v) wide_err++;
    end
    prev_v = valid;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // hold level v for n ticks; entered and left at a negedge
  task automatic drive(logic v, int n);
    int k = 0;
    rxd = v;
    while (k < n) begin
      if (tick) k++;
      @(negedge clk);
    end
  endtask

  function automatic int slen();
    return dbl ? 8 : 16;
  endfunction

  task automatic send_bit(logic v, logic [15:0] m);
    for (int s = 0; s < slen(); s++) drive(m[s] ? ~v : v, 1);
  endtask

  // gbit: 0 start, 1..nb data, nb+1 parity; gmask bit s flips sample s+1
  task automatic send_frame(logic [8:0] d, int nb, logic bad_par, logic stop_v, int stop_len,
                            int gbit, logic [15:0] gmask, int pre_idle);
    logic p = 1'b0;
    drive(1'b1, pre_idle);
    send_bit(1'b0, gbit == 0 ? gmask : 16'h0);
    for (int i = 0; i < nb; i++) begin
      send_bit(d[i], gbit == i + 1 ? gmask : 16'h0);
      p ^= d[i];
    end
    if (pmode == 2'b01 || pmode == 2'b10) begin
      p = p ^ (pmode == 2'b10) ^ bad_par;
      send_bit(p, gbit == nb + 1 ? gmask : 16'h0);
    end
    drive(stop_v, stop_len);
  endtask

  task automatic simple(logic [8:0] d, int nb);
    send_frame(d, nb, 1'b0, 1'b1, slen(), -1, 16'h0, 4);
  endtask

  task automatic settle();
    drive(1'b1, 24);
  endtask

  task automatic expect_one(int base, string req, logic [8:0] d, logic fe, logic pe);
    chk(req, "frame count", n_got - base, 1);
    if (n_got == base + 1 && base < 64) begin
      chk(req, "data", got_d[base], d);
      chk(req, "frame_err", got_fe[base], fe);
      chk(req, "parity_err", got_pe[base], pe);
    end
  endtask

  task automatic t_reset_state();
    chk("R9", "valid in reset", valid, 0);
    chk("R9", "data in reset", data, 0);
    chk("R9", "flags in reset", {ferr, perr}, 0);
  endtask

  task automatic t_normal();
    int b = n_got;
    dbl = 0; cbits = 8; pmode = 2'b00;
    simple(9'h0A5, 8); settle();
    expect_one(b, "R1_normal", 9'h0A5, 0, 0);
    b = n_got; simple(9'h03C, 8); settle();
    expect_one(b, "R4_lsb_first", 9'h03C, 0, 0);
  endtask

  task automatic t_double();
    int b = n_got;
    dbl = 1; cbits = 8; pmode = 2'b00;
    simple(9'h0C6, 8); settle();
    expect_one(b, "R1_double", 9'h0C6, 0, 0);
    dbl = 0;
  endtask

  task automatic t_sizes();
    int b = n_got;
    cbits = 9; simple(9'h1A5, 9); settle();
    expect_one(b, "R4_nine", 9'h1A5, 0, 0);
    b = n_got; cbits = 5; simple(9'h015, 5); settle();
    expect_one(b, "R4_five", 9'h015, 0, 0);
    b = n_got; cbits = 4; simple(9'h00B, 5); settle();
    expect_one(b, "R4_clamp", 9'h00B, 0, 0);
    cbits = 8;
  endtask

  task automatic t_parity();
    int b;
    cbits = 8;
    pmode = 2'b01; b = n_got; send_frame(9'h037, 8, 0, 1, 16, -1, 0, 4); settle();
    expect_one(b, "R5_even_ok", 9'h037, 0, 0);
    b = n_got; send_frame(9'h037, 8, 1, 1, 16, -1, 0, 4); settle();
    expect_one(b, "R5_even_bad", 9'h037, 0, 1);
    pmode = 2'b10; b = n_got; send_frame(9'h0E1, 8, 0, 1, 16, -1, 0, 4); settle();
    expect_one(b, "R5_odd_ok", 9'h0E1, 0, 0);
    b = n_got; send_frame(9'h0E1, 8, 1, 1, 16, -1, 0, 4); settle();
    expect_one(b, "R5_odd_bad", 9'h0E1, 0, 1);
    pmode = 2'b11; b = n_got; simple(9'h05B, 8); settle();
    expect_one(b, "R5_mode3_none", 9'h05B, 0, 0);
    pmode = 2'b00;
  endtask

  task automatic t_frame_err();
    int b = n_got;
    send_frame(9'h081, 8, 0, 0, 16, -1, 0, 4); settle();
    expect_one(b, "R6_low_stop", 9'h081, 1, 0);
    b = n_got; simple(9'h042, 8); settle();
    expect_one(b, "R6_recover", 9'h042, 0, 0);
  endtask

  task automatic t_glitch();
    int b = n_got;
    drive(1'b1, 4); drive(1'b0, 3); drive(1'b1, 40);
    chk("R3", "glitch frames", n_got - b, 0);
    drive(1'b0, 7); drive(1'b1, 40);
    chk("R3", "glitch before window", n_got - b, 0);
    simple(9'h099, 8); settle();
    expect_one(b, "R3_after_glitch", 9'h099, 0, 0);
  endtask

  task automatic t_vote();
    int b = n_got;
    dbl = 0;
    send_frame(9'h0FF, 8, 0, 1, 16, 3, 16'h0100, 4); settle();
    expect_one(b, "R2_one_flip", 9'h0FF, 0, 0);
    b = n_got; send_frame(9'h000, 8, 0, 1, 16, 2, 16'h0441, 4); settle();
    expect_one(b, "R2_outside", 9'h000, 0, 0);
    b = n_got; send_frame(9'h0FF, 8, 0, 1, 16, 5, 16'h0180, 4); settle();
    expect_one(b, "R2_two_flips", 9'h0EF, 0, 0);
    dbl = 1;
    b = n_got; send_frame(9'h0FF, 8, 0, 1, 8, 1, 16'h0010, 4); settle();
    expect_one(b, "R2_dbl_one_flip", 9'h0FF, 0, 0);
    b = n_got; send_frame(9'h0FF, 8, 0, 1, 8, 1, 16'h0028, 4); settle();
    expect_one(b, "R2_dbl_two_flips", 9'h0FE, 0, 0);
    dbl = 0;
  endtask

  task automatic t_back2back();
    int b = n_got;
    dbl = 0;
    send_frame(9'h05A, 8, 0, 1, 10, -1, 0, 4);
    send_frame(9'h0C3, 8, 0, 1, 16, -1, 0, 0); settle();
    chk("R7", "back-to-back count", n_got - b, 2);
    if (n_got == b + 2) begin
      chk("R7", "first data", got_d[b], 9'h05A);
      chk("R7", "second data", got_d[b+1], 9'h0C3);
      chk("R7", "flags", {got_fe[b], got_fe[b+1]}, 0);
    end
    dbl = 1; b = n_got;
    send_frame(9'h011, 8, 0, 1, 6, -1, 0, 4);
    send_frame(9'h0EE, 8, 0, 1, 8, -1, 0, 0); settle();
    chk("R7", "dbl back-to-back count", n_got - b, 2);
    if (n_got == b + 2) chk("R7", "dbl second data", got_d[b+1], 9'h0EE);
    dbl = 0;
  endtask

  task automatic t_slow_tick();
    int b = n_got;
    tick_div = 3; pmode = 2'b01;
    send_frame(9'h096, 8, 0, 1, 16, -1, 0, 4); settle();
    expect_one(b, "R1_slow_tick", 9'h096, 0, 0);
    tick_div = 1; pmode = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_reset_mid();
    int b;
    send_frame(9'h07E, 8, 0, 0, 16, -1, 0, 4); settle();
    chk("R9", "flag before reset", ferr, 1);
    drive(1'b0, 20);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "outputs in mid reset", {valid, ferr, perr, data}, 0);
    rxd = 1'b1;
    rst_n = 1'b1;
    settle();
    b = n_got; simple(9'h024, 8); settle();
    expect_one(b, "R9_after_reset", 9'h024, 0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    settle();
    t_normal();
    t_double();
    t_sizes();
    t_parity();
    t_frame_err();
    t_glitch();
    t_vote();
    t_back2back();
    t_slow_tick();
    t_reset_mid();
    chk("R8", "multi-cycle strobes", wide_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errs++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule